// File: doc/BRIEF.md
# Banked stack pointer selector

This unit holds the one-bit flag that decides which of four banked stack pointers the core works with. Each privilege level (0 to 3) owns a stack pointer register. When the flag is clear, every level shares the level-0 stack pointer. When the flag is set, each level uses its own. The unit reports the index of the live bank and gives the rest of the core one read port and one write port onto that bank.

Software reaches the flag through system-register requests. Each request carries five encoding fields, a direction and 64 bits of write data. Two encodings are recognised: a register form that can read or write, and an immediate form that only writes and takes the new flag value from the immediate field. A matching request made at privilege level 0 is refused and raises an undefined-instruction flag. A request that matches neither encoding is left alone.

Read data and the undefined flag are combinational in the request. The flag and the stack pointer banks update on the rising clock edge.

Top module: `banked_sp_select`

## Requirements
- R1: After reset the select flag is 1, every stack pointer bank holds zero, and `activeBank` equals `curLevel`.
- R2: A register-form read (op0=0b11, op1=0b000, CRn=0b0100, CRm=0b0010, op2=0b000, `reqWrite`=0) at level 1, 2 or 3 returns 63 zero bits above the select flag in bit 0 of `rdData`.
- R3: A register-form write at level 1, 2 or 3 loads the select flag from `wrData[0]` at the next rising edge. Bits 63 to 1 of `wrData` have no effect.
- R4: An immediate-form write (`reqWrite`=1, op0=0b00, op1=0b000, CRn=0b0100, op2=0b101) at level 1, 2 or 3 loads the select flag from bit 0 of the CRm field. CRm bits 3 to 1 are ignored.
- R5: A request that matches either form at level 0 raises `undefAcc` in that cycle, returns zero read data and leaves the select flag unchanged.
- R6: A request that matches neither form, including an immediate encoding with `reqWrite`=0, leaves the flag unchanged. It returns all-zero `rdData` and keeps `undefAcc` low.
- R7: `activeBank` is 0 while the flag is 0, and equals `curLevel` while the flag is 1.
- R8: With `spWrEn` high, `spWrData` is written into the bank that `activeBank` names in that cycle. That bank is chosen by the flag value from before any flag write in the same cycle. `spRdData` always shows the bank that `activeBank` names.
- R9: A stack pointer write changes only the addressed bank. The other three banks keep their values.
- R10: `undefAcc` is never high while `reqValid` is low, and a request with `reqValid` low has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| curLevel | input | 2 | Current privilege level |
| reqValid | input | 1 | System-register request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOp0 | input | 2 | Encoding field op0 |
| reqOp1 | input | 3 | Encoding field op1 |
| reqCrn | input | 4 | Encoding field CRn |
| reqCrm | input | 4 | Encoding field CRm (carries the immediate in the immediate form) |
| reqOp2 | input | 3 | Encoding field op2 |
| wrData | input | 64 | Register-form write data |
| rdData | output | 64 | Read data, zero unless a legal register-form read is made |
| undefAcc | output | 1 | Undefined-instruction indication |
| activeBank | output | 2 | Index of the stack pointer bank in use |
| spWrEn | input | 1 | Write the active stack pointer |
| spWrData | input | 64 | Value for the active stack pointer |
| spRdData | output | 64 | Value of the active stack pointer |

## Verification
The assertions assume that `curLevel` and the request fields are steady around each rising edge, and that a request lasts one cycle per transfer. The bench meets this by changing every input only on the falling edge and by clearing `reqValid` between table rows. The properties also assume that X values never reach the request inputs after reset. The bench therefore gives every field a defined value before reset is released.

// File: rtl/spsel_pkg.sv
package spsel_pkg;

  localparam int XLEN = 64;
  localparam int NUM_LEVELS = 4;
  localparam int LVL_W = $clog2(NUM_LEVELS);

  // register-form encoding
  localparam logic [1:0] REG_OP0 = 2'b11;
  localparam logic [2:0] REG_OP1 = 3'b000;
  localparam logic [3:0] REG_CRN = 4'b0100;
  localparam logic [3:0] REG_CRM = 4'b0010;
  localparam logic [2:0] REG_OP2 = 3'b000;

  // immediate-form encoding (CRm carries the value)
  localparam logic [1:0] IMM_OP0 = 2'b00;
  localparam logic [2:0] IMM_OP1 = 3'b000;
  localparam logic [3:0] IMM_CRN = 4'b0100;
  localparam logic [2:0] IMM_OP2 = 3'b101;

  typedef struct packed {
    logic selWrEn;
    logic selWrVal;
    logic rdEn;
  } selStrobe_t;

endpackage

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
  import spsel_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [1:0]    reqOp0,
  input  logic [2:0]    reqOp1,
  input  logic [3:0]    reqCrn,
  input  logic [3:0]    reqCrm,
  input  logic [2:0]    reqOp2,
  input  logic          wrBit0,
  input  logic [LW-1:0] curLevel,
  output selStrobe_t    strobe,
  output logic          undefAcc
);

  logic regHit;
  logic immHit;
  logic anyHit;
  logic privOk;

  always_comb begin
    regHit = (reqOp0 == REG_OP0) && (reqOp1 == REG_OP1) && (reqCrn == REG_CRN)
          && (reqCrm == REG_CRM) && (reqOp2 == REG_OP2);
    immHit = reqWrite && (reqOp0 == IMM_OP0) && (reqOp1 == IMM_OP1)
          && (reqCrn == IMM_CRN) && (reqOp2 == IMM_OP2);
    anyHit = reqValid && (regHit || immHit);
    privOk = (curLevel != '0);

    undefAcc        = anyHit && !privOk;
    strobe.selWrEn  = anyHit && privOk && reqWrite;
    strobe.selWrVal = immHit ? reqCrm[0] : wrBit0;
    strobe.rdEn     = reqValid && regHit && !reqWrite && privOk;
  end

endmodule

// File: rtl/bsp_datapath.sv
module bsp_datapath
  import spsel_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NL = NUM_LEVELS,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  selStrobe_t    strobe,
  input  logic [LW-1:0] curLevel,
  input  logic          spWrEn,
  input  logic [DW-1:0] spWrData,
  output logic [DW-1:0] rdData,
  output logic          selBit,
  output logic [LW-1:0] activeBank,
  output logic [DW-1:0] spRdData
);

  logic [DW-1:0] spBank [NL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selBit <= 1'b1;
    else if (strobe.selWrEn) selBit <= strobe.selWrVal;
  end

  always_comb begin
    activeBank = selBit ? curLevel : '0;
    rdData     = strobe.rdEn ? {{(DW-1){1'b0}}, selBit} : '0;
    spRdData   = spBank[activeBank];
  end

  for (genvar g = 0; g < NL; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) spBank[g] <= '0;
      else if (spWrEn && (activeBank == LW'(g))) spBank[g] <= spWrData;
    end
  end

endmodule

// File: rtl/banked_sp_select.sv
module banked_sp_select
  import spsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqOp0,
  input  logic [2:0]       reqOp1,
  input  logic [3:0]       reqCrn,
  input  logic [3:0]       reqCrm,
  input  logic [2:0]       reqOp2,
  input  logic [XLEN-1:0]  wrData,
  output logic [XLEN-1:0]  rdData,
  output logic             undefAcc,
  output logic [LVL_W-1:0] activeBank,
  input  logic             spWrEn,
  input  logic [XLEN-1:0]  spWrData,
  output logic [XLEN-1:0]  spRdData
);

  selStrobe_t strobe;
  logic       selBit;
  logic       unusedWrBits;

  assign unusedWrBits = ^wrData[XLEN-1:1];

  bsp_ctrl #(.LW(LVL_W)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqOp0   (reqOp0),
    .reqOp1   (reqOp1),
    .reqCrn   (reqCrn),
    .reqCrm   (reqCrm),
    .reqOp2   (reqOp2),
    .wrBit0   (wrData[0]),
    .curLevel (curLevel),
    .strobe   (strobe),
    .undefAcc (undefAcc)
  );

  bsp_datapath #(.DW(XLEN), .NL(NUM_LEVELS), .LW(LVL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .curLevel   (curLevel),
    .spWrEn     (spWrEn),
    .spWrData   (spWrData),
    .rdData     (rdData),
    .selBit     (selBit),
    .activeBank (activeBank),
    .spRdData   (spRdData)
  );

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker
  import spsel_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] curLevel,
  input logic             reqValid,
  input logic             reqWrite,
  input logic [1:0]       reqOp0,
  input logic [2:0]       reqOp1,
  input logic [3:0]       reqCrn,
  input logic [3:0]       reqCrm,
  input logic [2:0]       reqOp2,
  input logic             wrBit0,
  input logic [XLEN-1:0]  rdData,
  input logic             undefAcc,
  input logic [LVL_W-1:0] activeBank,
  input logic             selBit
);

  logic regEnc;
  logic immEnc;
  assign regEnc = (reqOp0 == REG_OP0) && (reqOp1 == REG_OP1) && (reqCrn == REG_CRN)
               && (reqCrm == REG_CRM) && (reqOp2 == REG_OP2);
  assign immEnc = reqWrite && (reqOp0 == IMM_OP0) && (reqOp1 == IMM_OP1)
               && (reqCrn == IMM_CRN) && (reqOp2 == IMM_OP2);

  a_r2_read_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[XLEN-1:1] == '0);

  a_r3_reg_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && regEnc && curLevel != '0) |=> (selBit == $past(wrBit0)));

  a_r4_imm_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && immEnc && curLevel != '0) |=> (selBit == $past(reqCrm[0])));

  a_r5_level0_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (regEnc || immEnc) && curLevel == '0) |=> $stable(selBit));

  a_r6_nomatch_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !regEnc && !immEnc) |-> (!undefAcc && rdData == '0));

  a_r7_bank_index: assert property (@(posedge clk) disable iff (!rstN)
    activeBank == (selBit ? curLevel : '0));

  a_r10_undef_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    undefAcc |-> reqValid);

  a_r10_idle_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(selBit));

endmodule

bind banked_sp_select bsp_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .curLevel   (curLevel),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqOp0     (reqOp0),
  .reqOp1     (reqOp1),
  .reqCrn     (reqCrn),
  .reqCrm     (reqCrm),
  .reqOp2     (reqOp2),
  .wrBit0     (wrData[0]),
  .rdData     (rdData),
  .undefAcc   (undefAcc),
  .activeBank (activeBank),
  .selBit     (selBit)
);

// File: tb/banked_sp_select_tb.sv
`timescale 1ns/1ps
module banked_sp_select_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  curLevel = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqOp0 = '0;
  logic [2:0]  reqOp1 = '0;
  logic [3:0]  reqCrn = '0;
  logic [3:0]  reqCrm = '0;
  logic [2:0]  reqOp2 = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        undefAcc;
  logic [1:0]  activeBank;
  logic        spWrEn = 1'b0;
  logic [63:0] spWrData = '0;
  logic [63:0] spRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  banked_sp_select u_dut (
    .clk(clk), .rstN(rstN), .curLevel(curLevel), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn),
    .reqCrm(reqCrm), .reqOp2(reqOp2), .wrData(wrData), .rdData(rdData),
    .undefAcc(undefAcc), .activeBank(activeBank), .spWrEn(spWrEn),
    .spWrData(spWrData), .spRdData(spRdData)
  );

  // level,wr,op0,op1,crn,crm,op2,wd0,expUndef,expRd,expBankAfter
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {2'd1,1'b0,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b0,1'b1,2'd1},
    {2'd2,1'b1,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b0,1'b0,2'd0},
    {2'd2,1'b0,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b0,1'b0,2'd0},
    {2'd3,1'b1,2'b00,3'b000,4'b0100,4'b0001,3'b101,1'b0,1'b0,1'b0,2'd3},
    {2'd0,1'b1,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b1,1'b0,2'd0},
    {2'd3,1'b0,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b0,1'b1,2'd3},
    {2'd1,1'b1,2'b11,3'b000,4'b0100,4'b0011,3'b000,1'b0,1'b0,1'b0,2'd1},
    {2'd1,1'b0,2'b11,3'b000,4'b0100,4'b0010,3'b001,1'b0,1'b0,1'b0,2'd1},
    {2'd0,1'b1,2'b00,3'b000,4'b0100,4'b0000,3'b101,1'b0,1'b1,1'b0,2'd0},
    {2'd2,1'b0,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b0,1'b1,2'd2},
    {2'd1,1'b1,2'b00,3'b000,4'b0100,4'b1110,3'b101,1'b0,1'b0,1'b0,2'd0},
    {2'd3,1'b1,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b1,1'b0,1'b0,2'd3},
    {2'd0,1'b0,2'b11,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b1,1'b0,2'd0},
    {2'd1,1'b0,2'b01,3'b000,4'b0100,4'b0010,3'b000,1'b0,1'b0,1'b0,2'd1},
    {2'd2,1'b0,2'b00,3'b000,4'b0100,4'b0001,3'b101,1'b0,1'b0,1'b0,2'd2}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setReq(input logic [1:0] lvl, input logic wr, input logic [1:0] o0,
                        input logic [2:0] o1, input logic [3:0] cn, input logic [3:0] cm,
                        input logic [2:0] o2, input logic [63:0] wd);
    curLevel = lvl; reqValid = 1'b1; reqWrite = wr; reqOp0 = o0; reqOp1 = o1;
    reqCrn = cn; reqCrm = cm; reqOp2 = o2; wrData = wd;
  endtask

  task automatic clrReq();
    reqValid = 1'b0; reqWrite = 1'b0; spWrEn = 1'b0;
  endtask

  // register-form write of flag value v at level lvl, one cycle
  task automatic regWrite(input logic [1:0] lvl, input logic v);
    @(negedge clk);
    setReq(lvl, 1'b1, 2'b11, 3'b000, 4'b0100, 4'b0010, 3'b000, {63'd0, v});
    @(negedge clk);
    clrReq();
  endtask

  task automatic spWrite(input logic [1:0] lvl, input logic [63:0] v);
    @(negedge clk);
    curLevel = lvl; spWrEn = 1'b1; spWrData = v;
    @(negedge clk);
    spWrEn = 1'b0;
  endtask

  task automatic spExpect(input string tag, input logic [1:0] lvl, input logic [63:0] v);
    @(negedge clk);
    curLevel = lvl;
    #1;
    chk(tag, spRdData, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int l = 1; l < 4; l++) begin
      @(negedge clk);
      curLevel = 2'(l);
      #1;
      chk("R1 bank equals level after reset", 64'(activeBank), 64'(l));
      chk("R1 stack pointer zero after reset", spRdData, 64'd0);
    end
    chk("R1 no undef while idle", 64'(undefAcc), 64'd0);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      setReq(VEC[i][23:22], VEC[i][21], VEC[i][20:19], VEC[i][18:16], VEC[i][15:12],
             VEC[i][11:8], VEC[i][7:5], {63'h7FFF_FFFF_FFFF_FFFF, VEC[i][4]});
      #1;
      chk($sformatf("R5 undef flag, vector %0d", i), 64'(undefAcc), 64'(VEC[i][3]));
      chk($sformatf("R2 read data, vector %0d", i), rdData, {63'd0, VEC[i][2]});
      @(negedge clk);
      clrReq();
      #1;
      chk($sformatf("R7 bank after request (R3 R4 R6), vector %0d", i),
          64'(activeBank), 64'(VEC[i][1:0]));
    end

    // flag is 1 here; R8 R9: per-level banks
    spWrite(2'd1, 64'h1111);
    spWrite(2'd2, 64'h2222);
    spWrite(2'd3, 64'h3333);
    spExpect("R9 bank1 kept", 2'd1, 64'h1111);
    spExpect("R9 bank2 kept", 2'd2, 64'h2222);
    spExpect("R8 bank3 written", 2'd3, 64'h3333);
    spExpect("R9 bank0 untouched", 2'd0, 64'd0);

    // R8: same-cycle flag write and stack pointer write uses old selection
    @(negedge clk);
    setReq(2'd2, 1'b1, 2'b11, 3'b000, 4'b0100, 4'b0010, 3'b000, 64'd0);
    spWrEn = 1'b1; spWrData = 64'hAAAA;
    @(negedge clk);
    clrReq();
    #1;
    chk("R8 shared bank untouched by same-cycle write", spRdData, 64'd0);
    regWrite(2'd2, 1'b1);
    spExpect("R8 same-cycle write landed in old bank", 2'd2, 64'hAAAA);

    // R8: with flag 0 writes go to bank0 at any level
    regWrite(2'd3, 1'b0);
    spWrite(2'd3, 64'h5555);
    spExpect("R8 shared bank at level1", 2'd1, 64'h5555);
    regWrite(2'd3, 1'b1);
    spExpect("R9 bank3 not hit while flag 0", 2'd3, 64'h3333);

    // R10: matching write with reqValid low does nothing
    @(negedge clk);
    setReq(2'd0, 1'b1, 2'b11, 3'b000, 4'b0100, 4'b0010, 3'b000, 64'd0);
    reqValid = 1'b0;
    #1;
    chk("R10 no undef without valid", 64'(undefAcc), 64'd0);
    @(negedge clk);
    curLevel = 2'd1; reqOp0 = 2'b00; reqOp2 = 3'b101; reqCrm = 4'b0000;
    @(negedge clk);
    #1;
    chk("R10 flag kept without valid", 64'(activeBank), 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule